// File: doc/BRIEF.md
# Multi-Row Reconfigurable Loop Accelerator

This block runs the body of an integer loop on a two-dimensional array of single-cycle 32-bit functional units. The units are grouped into rows, and the rows fire one after another, one row per clock. Row 0 reads a bank of live registers. Every later row reads the registered outputs of the row above it. At the end of an iteration the outputs of the last row are written back into the live registers, so loop-carried values move from one iteration to the next. A unit set to the pass operation carries a value down unchanged.

Up to six loop configurations are held on chip. Each one sets, for every unit, an operation, two source selects and a 32-bit constant. Each one also names the last-row unit whose bit 0 ends the loop. Configuration words arrive on their own stream and may be loaded while operands are still arriving. The operands come in on a valid/ready stream and fill the live registers in order. The array then iterates until the exit bit is set. The live registers are then returned in order on an output stream, and the block waits for the next set of operands.

Top module: `loop_array_accel`

## Requirements
- R1: After reset, in_ready_o=1, out_valid_o=0 and cfg_ready_o=1. The active slot is 0. Every unit of every slot holds op 0 (pass) with both sources equal to the unit's own index. The exit unit of every slot is 0, so the reset configuration is an identity loop that stops after one iteration when live register 0 is odd.
- R2: Exactly UNITS words are accepted on the operand stream while in_ready_o=1. They are written to live registers 0, 1, … in arrival order, and execution starts on the cycle after the last one is accepted.
- R3: Each row takes exactly one cycle and every row fires in each iteration, even when the later rows only pass values. The number of cycles from the acceptance of the last operand to out_valid_o is exactly iterations × NUM_ROWS.
- R4: In a 4-bit source select, bit 3 = 1 picks the unit's 32-bit constant. Otherwise bits [1:0] pick that unit index among the outputs of the previous row, or among the live registers for row 0.
- R5: Op codes: 0 pass A, 1 A+B, 2 A−B, 3 AND, 4 OR, 5 XOR, 6 A<<B[4:0], 7 A>>B[4:0] (logical), 8 signed A<B, 9 A==B, 10 A!=B, 11 any byte lane of A equals the same lane of B. Codes 8 to 11 give 0 or 1, and codes 12 to 15 give 0.
- R6: At the end of each iteration the last row's unit u is written to live register u, and the next iteration's row 0 reads these new values.
- R7: If bit 0 of the last-row unit named by the active slot's exit field is 1 at the end of an iteration, the results are returned. Otherwise the next iteration starts at once.
- R8: The UNITS live registers are returned in order 0, 1, … on the output stream. Each word is held stable while out_ready_i=0. After the last word is accepted, in_ready_o returns to 1.
- R9: A configuration word is accepted when cfg_valid_i and cfg_ready_o are both high. Kind 0 writes the op, sources and constant to (slot, row, unit). Kind 1 sets the slot's exit unit from the unit field. Kind 2 makes the slot active. Kind 3 and slots ≥ NUM_CFG are ignored. Writes to one slot leave the others unchanged.
- R10: cfg_ready_o is low only while iterating, so configuration may be selected while operands load. in_ready_o and out_valid_o are both low while iterating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand word valid |
| in_ready_o | output | 1 | Operand word accepted |
| in_data_i | input | 32 | Operand word |
| cfg_valid_i | input | 1 | Configuration word valid |
| cfg_ready_o | output | 1 | Configuration word accepted |
| cfg_kind_i | input | 2 | 0 unit write, 1 exit unit, 2 select slot |
| cfg_slot_i | input | 3 | Configuration slot |
| cfg_row_i | input | 2 | Row of a unit write |
| cfg_unit_i | input | 2 | Unit of a unit write, or exit unit |
| cfg_op_i | input | 4 | Operation code |
| cfg_src_a_i | input | 4 | Source select A |
| cfg_src_b_i | input | 4 | Source select B |
| cfg_imm_i | input | 32 | Unit constant |
| out_valid_o | output | 1 | Result word valid |
| out_ready_i | input | 1 | Result word accepted |
| out_data_o | output | 32 | Result word |

## Verification
The reset identity configuration is run first, which separates a wrong reset image or a broken passthrough from everything else. Three programmed slots follow, each with its own purpose:
- A counting-sum loop, whose result depends on live-register feedback, so an error in loop-carried state gives a wrong sum.
- A countdown loop that does all its work in row 0, so a design that skipped idle rows would give a short cycle count.
- A single-iteration slot that uses every remaining operation and constant source, so each op code is checked against its own arithmetic.

Directed cases cover the one-iteration minimum and a forced byte-lane match. Random runs switch slots while operands are loading, with random output stalls, which exposes cross-slot corruption and unstable output data.

// File: rtl/lra_pkg.sv
package lra_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned SRC_W = 4;

  typedef enum logic [3:0] {
    OP_PASS = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_AND = 4'd3,
    OP_OR   = 4'd4, OP_XOR = 4'd5, OP_SHL = 4'd6, OP_SHR = 4'd7,
    OP_SLT  = 4'd8, OP_EQ  = 4'd9, OP_NE  = 4'd10, OP_PCMP = 4'd11
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [SRC_W-1:0] src_a;
    logic [SRC_W-1:0] src_b;
    logic [DW-1:0]    imm;
  } unit_cfg_t;

  typedef enum logic [1:0] {
    CFG_UNIT = 2'd0, CFG_EXIT = 2'd1, CFG_SEL = 2'd2, CFG_NONE = 2'd3
  } cfg_kind_e;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0, ST_RUN = 2'd1, ST_DRAIN = 2'd2
  } state_e;
endpackage

// File: rtl/lra_fu.sv
module lra_fu
  import lra_pkg::*;
#(
  parameter int unsigned UNITS = 4
) (
  input  unit_cfg_t     cfg_i,
  input  logic [DW-1:0] opnd_i [UNITS],
  output logic [DW-1:0] res_o
);
  localparam int unsigned IDX_W = $clog2(UNITS);
  localparam int unsigned LANES = DW / 8;

  logic [DW-1:0] a, b;
  logic          lane_hit;

  always_comb begin
    a = cfg_i.src_a[SRC_W-1] ? cfg_i.imm : opnd_i[cfg_i.src_a[IDX_W-1:0]];
    b = cfg_i.src_b[SRC_W-1] ? cfg_i.imm : opnd_i[cfg_i.src_b[IDX_W-1:0]];
    lane_hit = 1'b0;
    for (int l = 0; l < LANES; l++) lane_hit |= (a[l*8+:8] == b[l*8+:8]);
    unique case (cfg_i.op)
      OP_PASS: res_o = a;
      OP_ADD:  res_o = a + b;
      OP_SUB:  res_o = a - b;
      OP_AND:  res_o = a & b;
      OP_OR:   res_o = a | b;
      OP_XOR:  res_o = a ^ b;
      OP_SHL:  res_o = a << b[4:0];
      OP_SHR:  res_o = a >> b[4:0];
      OP_SLT:  res_o = DW'($signed(a) < $signed(b));
      OP_EQ:   res_o = DW'(a == b);
      OP_NE:   res_o = DW'(a != b);
      OP_PCMP: res_o = DW'(lane_hit);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/lra_cfg_store.sv
module lra_cfg_store
  import lra_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 3,
  parameter int unsigned UNITS    = 4,
  parameter int unsigned NUM_CFG  = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  cfg_kind_e                   kind_i,
  input  logic [$clog2(NUM_CFG)-1:0]  slot_i,
  input  logic [$clog2(NUM_ROWS)-1:0] row_i,
  input  logic [$clog2(UNITS)-1:0]    unit_i,
  input  unit_cfg_t                   word_i,
  output unit_cfg_t                   cur_o [NUM_ROWS][UNITS],
  output logic [$clog2(UNITS)-1:0]    exit_o
);
  localparam int unsigned SLOT_W = $clog2(NUM_CFG);
  localparam int unsigned IDX_W  = $clog2(UNITS);

  unit_cfg_t         mem_q  [NUM_CFG][NUM_ROWS][UNITS];
  logic [IDX_W-1:0]  exit_q [NUM_CFG];
  logic [SLOT_W-1:0] act_q;
  logic              slot_ok;

  assign slot_ok = int'(slot_i) < NUM_CFG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      for (int s = 0; s < NUM_CFG; s++) begin
        exit_q[s] <= '0;
        for (int r = 0; r < NUM_ROWS; r++)
          for (int u = 0; u < UNITS; u++)
            mem_q[s][r][u] <= '{op: OP_PASS, src_a: SRC_W'(u), src_b: SRC_W'(u), imm: '0};
      end
    end else if (wr_en_i && slot_ok) begin
      unique case (kind_i)
        CFG_UNIT: if (int'(row_i) < NUM_ROWS && int'(unit_i) < UNITS)
                    mem_q[slot_i][row_i][unit_i] <= word_i;
        CFG_EXIT: exit_q[slot_i] <= unit_i;
        CFG_SEL:  act_q <= slot_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_ROWS; r++)
      for (int u = 0; u < UNITS; u++)
        cur_o[r][u] = mem_q[act_q][r][u];
    exit_o = exit_q[act_q];
  end
endmodule

// File: rtl/lra_seq.sv
module lra_seq
  import lra_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 3,
  parameter int unsigned UNITS    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic                     out_ready_i,
  input  logic                     exit_i,
  output logic                     in_ready_o,
  output logic                     out_valid_o,
  output logic                     cfg_ready_o,
  output logic                     load_we_o,
  output logic [$clog2(UNITS)-1:0] idx_o,
  output logic [NUM_ROWS-1:0]      row_act_o
);
  localparam int unsigned IDX_W = $clog2(UNITS);
  localparam int unsigned ROW_W = $clog2(NUM_ROWS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(UNITS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);

  state_e           st_q;
  logic [IDX_W-1:0] idx_q;
  logic [ROW_W-1:0] row_q;

  assign in_ready_o  = (st_q == ST_LOAD);
  assign out_valid_o = (st_q == ST_DRAIN);
  assign cfg_ready_o = (st_q != ST_RUN);
  assign load_we_o   = in_ready_o && in_valid_i;
  assign idx_o       = idx_q;

  always_comb
    for (int r = 0; r < NUM_ROWS; r++)
      row_act_o[r] = (st_q == ST_RUN) && (row_q == ROW_W'(r));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_LOAD;
      idx_q <= '0;
      row_q <= '0;
    end else begin
      unique case (st_q)
        ST_LOAD: if (in_valid_i) begin
          if (idx_q == IDX_LAST) begin
            st_q  <= ST_RUN;
            idx_q <= '0;
            row_q <= '0;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_RUN: begin
          if (row_q == ROW_LAST) begin
            row_q <= '0;
            if (exit_i) st_q <= ST_DRAIN;
          end else row_q <= row_q + 1'b1;
        end
        ST_DRAIN: if (out_ready_i) begin
          if (idx_q == IDX_LAST) begin
            st_q  <= ST_LOAD;
            idx_q <= '0;
          end else idx_q <= idx_q + 1'b1;
        end
        default: st_q <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/loop_array_accel.sv
module loop_array_accel
  import lra_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 3,
  parameter int unsigned UNITS    = 4,
  parameter int unsigned NUM_CFG  = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  output logic                        in_ready_o,
  input  logic [31:0]                 in_data_i,
  input  logic                        cfg_valid_i,
  output logic                        cfg_ready_o,
  input  logic [1:0]                  cfg_kind_i,
  input  logic [$clog2(NUM_CFG)-1:0]  cfg_slot_i,
  input  logic [$clog2(NUM_ROWS)-1:0] cfg_row_i,
  input  logic [$clog2(UNITS)-1:0]    cfg_unit_i,
  input  logic [3:0]                  cfg_op_i,
  input  logic [3:0]                  cfg_src_a_i,
  input  logic [3:0]                  cfg_src_b_i,
  input  logic [31:0]                 cfg_imm_i,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic [31:0]                 out_data_o
);
  localparam int unsigned IDX_W = $clog2(UNITS);

  unit_cfg_t         cur_cfg [NUM_ROWS][UNITS];
  unit_cfg_t         cfg_word;
  logic [IDX_W-1:0]  exit_sel;
  logic [IDX_W-1:0]  idx;
  logic [NUM_ROWS-1:0] row_act;
  logic              load_we, exit_flag;

  logic [DW-1:0] live_q  [UNITS];
  logic [DW-1:0] stage_q [NUM_ROWS-1][UNITS];
  logic [DW-1:0] row_in  [NUM_ROWS][UNITS];
  logic [DW-1:0] row_out [NUM_ROWS][UNITS];

  assign cfg_word = '{op: op_e'(cfg_op_i), src_a: cfg_src_a_i, src_b: cfg_src_b_i, imm: cfg_imm_i};

  lra_cfg_store #(.NUM_ROWS(NUM_ROWS), .UNITS(UNITS), .NUM_CFG(NUM_CFG)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (cfg_valid_i && cfg_ready_o),
    .kind_i  (cfg_kind_e'(cfg_kind_i)),
    .slot_i  (cfg_slot_i),
    .row_i   (cfg_row_i),
    .unit_i  (cfg_unit_i),
    .word_i  (cfg_word),
    .cur_o   (cur_cfg),
    .exit_o  (exit_sel)
  );

  lra_seq #(.NUM_ROWS(NUM_ROWS), .UNITS(UNITS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .exit_i      (exit_flag),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .cfg_ready_o (cfg_ready_o),
    .load_we_o   (load_we),
    .idx_o       (idx),
    .row_act_o   (row_act)
  );

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    for (genvar u = 0; u < UNITS; u++) begin : g_unit
      if (r == 0) begin : g_first
        assign row_in[r][u] = live_q[u];
      end else begin : g_next
        assign row_in[r][u] = stage_q[r-1][u];
      end
      lra_fu #(.UNITS(UNITS)) u_fu (
        .cfg_i  (cur_cfg[r][u]),
        .opnd_i (row_in[r]),
        .res_o  (row_out[r][u])
      );
    end
    if (r < NUM_ROWS - 1) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int u = 0; u < UNITS; u++) stage_q[r][u] <= '0;
        end else if (row_act[r]) begin
          for (int u = 0; u < UNITS; u++) stage_q[r][u] <= row_out[r][u];
        end
      end
    end
  end

  // last row closes the iteration: results feed back as next live-ins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int u = 0; u < UNITS; u++) live_q[u] <= '0;
    end else if (load_we) begin
      live_q[idx] <= in_data_i;
    end else if (row_act[NUM_ROWS-1]) begin
      for (int u = 0; u < UNITS; u++) live_q[u] <= row_out[NUM_ROWS-1][u];
    end
  end

  assign exit_flag  = row_out[NUM_ROWS-1][exit_sel][0];
  assign out_data_o = live_q[idx];
endmodule

// File: rtl/lra_chk.sv
module lra_chk #(
  parameter int unsigned NUM_ROWS = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_ready_o,
  input logic        cfg_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [31:0] out_data_o
);
  int unsigned run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_cnt <= 0;
    else if (in_ready_o) run_cnt <= 0;
    else if (!cfg_ready_o) run_cnt <= run_cnt + 1;
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_valid_o) |-> $past(out_ready_i) && in_ready_o);

  assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  assert_run_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ready_o |-> !in_ready_o && !out_valid_o);

  assert_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> run_cnt != 0 && (run_cnt % NUM_ROWS) == 0);
endmodule

bind loop_array_accel lra_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .cfg_ready_o (cfg_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o)
);

// File: tb/sim_loop_array_accel.sv
module sim_loop_array_accel;
  localparam int NR = 3, NU = 4, NC = 6;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, cfg_valid_i = 1'b0, out_ready_i = 1'b0;
  logic [31:0] in_data_i = '0, cfg_imm_i = '0;
  logic [1:0]  cfg_kind_i = '0, cfg_row_i = '0, cfg_unit_i = '0;
  logic [2:0]  cfg_slot_i = '0;
  logic [3:0]  cfg_op_i = '0, cfg_src_a_i = '0, cfg_src_b_i = '0;
  logic        in_ready_o, cfg_ready_o, out_valid_o;
  logic [31:0] out_data_o;

  always #5 clk_i = ~clk_i;

  loop_array_accel #(.NUM_ROWS(NR), .UNITS(NU), .NUM_CFG(NC)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  // bench image of the configuration state
  logic [3:0]  m_op  [NC][NR][NU];
  logic [3:0]  m_sa  [NC][NR][NU];
  logic [3:0]  m_sb  [NC][NR][NU];
  logic [31:0] m_imm [NC][NR][NU];
  int          m_exit [NC];
  int          m_act = 0;
  logic [31:0] m_out [NU];
  int          m_iter;

  localparam logic [3:0] K = 4'h8;

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_alu(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    logic hit = 1'b0;
    for (int l = 0; l < 4; l++) if (a[l*8+:8] == b[l*8+:8]) hit = 1'b1;
    case (op)
      4'd0: return a;
      4'd1: return a + b;
      4'd2: return a - b;
      4'd3: return a & b;
      4'd4: return a | b;
      4'd5: return a ^ b;
      4'd6: return a << b[4:0];
      4'd7: return a >> b[4:0];
      4'd8: return {31'b0, $signed(a) < $signed(b)};
      4'd9: return {31'b0, a == b};
      4'd10: return {31'b0, a != b};
      4'd11: return {31'b0, hit};
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model(logic [31:0] init [NU]);
    logic [31:0] cur [NU];
    logic [31:0] nxt [NU];
    logic [31:0] a, b;
    cur = init;
    m_iter = 0;
    for (int it = 0; it < 5000; it++) begin
      for (int r = 0; r < NR; r++) begin
        for (int u = 0; u < NU; u++) begin
          a = m_sa[m_act][r][u][3] ? m_imm[m_act][r][u] : cur[m_sa[m_act][r][u][1:0]];
          b = m_sb[m_act][r][u][3] ? m_imm[m_act][r][u] : cur[m_sb[m_act][r][u][1:0]];
          nxt[u] = m_alu(m_op[m_act][r][u], a, b);
        end
        cur = nxt;
      end
      m_iter++;
      if (cur[m_exit[m_act]][0]) break;
    end
    m_out = cur;
  endfunction

  task automatic cfg_send(int kind, int slot, int row, int unit, int op, int sa, int sb, logic [31:0] imm);
    @(negedge clk_i);
    cfg_valid_i = 1'b1; cfg_kind_i = 2'(kind); cfg_slot_i = 3'(slot);
    cfg_row_i = 2'(row); cfg_unit_i = 2'(unit); cfg_op_i = 4'(op);
    cfg_src_a_i = 4'(sa); cfg_src_b_i = 4'(sb); cfg_imm_i = imm;
    @(posedge clk_i);
    @(negedge clk_i);
    cfg_valid_i = 1'b0;
  endtask

  task automatic set_unit(int slot, int row, int unit, int op, int sa, int sb, logic [31:0] imm);
    m_op[slot][row][unit] = 4'(op); m_sa[slot][row][unit] = 4'(sa);
    m_sb[slot][row][unit] = 4'(sb); m_imm[slot][row][unit] = imm;
    cfg_send(0, slot, row, unit, op, sa, sb, imm);
  endtask

  task automatic set_exit(int slot, int unit);
    m_exit[slot] = unit;
    cfg_send(1, slot, 0, unit, 0, 0, 0, 32'h0);
  endtask

  // sel >= 0: select that slot while the operands are streaming in (R10)
  task automatic run_job(logic [31:0] ops [NU], int sel, string tag);
    int cyc = 0;
    fork
      begin
        if (sel >= 0) begin
          cfg_send(2, sel, 0, 0, 0, 0, 0, 32'h0);
          m_act = sel;
        end
      end
      begin
        for (int i = 0; i < NU; i++) begin
          @(negedge clk_i);
          if (i == 0) chk(32'(in_ready_o), 32'd1, {"R2 ready before operands ", tag});
          in_valid_i = 1'b1; in_data_i = ops[i];
          @(posedge clk_i);
        end
      end
    join
    model(ops);
    forever begin
      @(negedge clk_i);
      in_valid_i = 1'b0;
      if (out_valid_o) break;
      if (cyc == 0) begin
        chk(32'(cfg_ready_o), 32'd0, {"R10 cfg_ready low while iterating ", tag});
        chk(32'(in_ready_o), 32'd0, {"R10 in_ready low while iterating ", tag});
      end
      cyc++;
      if (cyc > 20000) break;
    end
    chk(32'(cyc), 32'(m_iter * NR), {"R3 run length ", tag});
    for (int j = 0; j < NU; j++) begin
      int stall = int'($urandom_range(0, 2));
      chk(out_data_o, m_out[j], {"R8 result order ", tag});
      for (int s = 0; s < stall; s++) begin
        @(negedge clk_i);
        chk(32'(out_valid_o), 32'd1, "R8 valid held under stall");
        chk(out_data_o, m_out[j], "R8 data stable under stall");
      end
      out_ready_i = 1'b1;
      @(posedge clk_i);
      @(negedge clk_i);
      out_ready_i = 1'b0;
    end
    chk(32'(in_ready_o), 32'd1, {"R8 back to operand accept ", tag});
    chk(32'(out_valid_o), 32'd0, {"R8 valid drops after last ", tag});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] ops [NU];
    void'($urandom(32'h5A17));
    for (int s = 0; s < NC; s++) begin
      m_exit[s] = 0;
      for (int r = 0; r < NR; r++)
        for (int u = 0; u < NU; u++) begin
          m_op[s][r][u] = 4'd0; m_sa[s][r][u] = 4'(u); m_sb[s][r][u] = 4'(u); m_imm[s][r][u] = '0;
        end
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(32'(in_ready_o), 32'd1, "R1 in_ready after reset");
    chk(32'(out_valid_o), 32'd0, "R1 out_valid after reset");
    chk(32'(cfg_ready_o), 32'd1, "R1 cfg_ready after reset");

    // R1/R6: reset image is an identity loop that stops at once on odd live 0
    ops = '{32'h3, 32'hDEAD_BEEF, 32'h1234_5678, 32'hFFFF_0000};
    run_job(ops, -1, "R1 reset passthrough");
    chk(32'(m_iter), 32'd1, "R1 identity loop single iteration");

    // slot 0: sum loop, exit from row 1 unit 2 (R6, R7)
    set_unit(0, 0, 0, 1, 0, K, 32'd1);
    set_unit(0, 0, 1, 1, 1, 0, 32'd0);
    set_unit(0, 1, 2, 9, 0, 3, 32'd0);
    set_exit(0, 2);
    // slot 1: countdown, all work in row 0 (R3)
    set_unit(1, 0, 0, 2, 0, K, 32'd1);
    set_unit(1, 0, 1, 5, 1, 2, 32'd0);
    set_unit(1, 0, 2, 6, 2, K, 32'd1);
    set_unit(1, 0, 3, 9, 0, K, 32'd1);
    set_exit(1, 3);
    // slot 5: operation coverage, one iteration (R4, R5)
    set_unit(5, 0, 0, 3, 0, 1, 32'd0);
    set_unit(5, 0, 1, 4, 0, 1, 32'd0);
    set_unit(5, 0, 2, 7, 0, 2, 32'd0);
    set_unit(5, 0, 3, 8, 1, 0, 32'd0);
    set_unit(5, 1, 0, 5, 0, 1, 32'd0);
    set_unit(5, 1, 1, 11, 1, K, 32'h00AB_00CD);
    set_unit(5, 1, 2, 1, 2, 3, 32'd0);
    set_unit(5, 1, 3, 2, 3, K, 32'd0);
    set_unit(5, 2, 0, 6, 0, 2, 32'd0);
    set_unit(5, 2, 3, 10, 3, K, 32'hFFFF_FFFF);
    set_exit(5, 3);

    // directed corners
    ops = '{32'd0, 32'd7, 32'd9, 32'd1};
    run_job(ops, 0, "R6 sum loop minimum");
    chk(32'(m_iter), 32'd1, "R7 exit after first iteration");
    ops = '{32'd2, 32'd0, 32'd0, 32'd12};
    run_job(ops, 0, "R6 sum loop 2..11");
    chk(m_out[1], 32'd65, "R6 accumulated sum 2..11");
    ops = '{32'd30, 32'hA5A5_0F0F, 32'h1, 32'h0};
    run_job(ops, 1, "R3 countdown thirty");
    chk(32'(m_iter), 32'd30, "R7 countdown iterations");
    ops = '{32'h00AB_0000, 32'h0000_00CD, 32'd4, 32'h8000_0000};
    run_job(ops, 5, "R5 lane match");
    chk(m_out[1], 32'd1, "R5 byte-lane compare hit");
    ops = '{32'hF000_0001, 32'h8000_0000, 32'd31, 32'd5};
    run_job(ops, 5, "R4 R5 signed and shift edge");

    // random runs, slot switched while operands load
    for (int n = 0; n < 30; n++) begin
      int pick = int'($urandom_range(0, 2));
      int slot = (pick == 0) ? 0 : (pick == 1) ? 1 : 5;
      for (int i = 0; i < NU; i++) ops[i] = $urandom;
      if (slot == 0) begin
        ops[0] = $urandom_range(0, 5);
        ops[3] = ops[0] + $urandom_range(1, 20);
      end else if (slot == 1) begin
        ops[0] = $urandom_range(1, 25);
      end
      run_job(ops, slot, slot == 0 ? "R9 random slot0" : slot == 1 ? "R9 random slot1" : "R9 random slot5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule